// File: doc/BRIEF.md
# AES-128 Feed-Forward Encryption Pipeline

This block encrypts a stream of 128-bit blocks under AES-128. It has no stall path. Each clock cycle it can accept one plaintext block, qualified by a valid bit. The matching ciphertext leaves, qualified by its own valid bit, a fixed number of cycles later. The block does not compute the round keys. Its surroundings compute all eleven of them and present them on one wide input, which stays quiet for as long as the session key is unchanged.

The datapath has eleven register stages. The first stage holds the plaintext XORed with the initial round key. Each of the next ten stages holds the result of one cipher round. In the first nine rounds a byte substitution comes first, then a row rotation, then a column mix, then the key XOR. The tenth round leaves out the column mix. The substitution bytes are computed from the finite-field inverse followed by the affine map, so no lookup table is stored. A valid bit travels next to each stage. Each data register loads only when the valid bit entering its stage is set.

Top module: `aes128_pipe`

## Requirements
- R1: While reset is asserted, and afterwards until the first accepted block has crossed the pipeline, `valid_out` is 0.
- R2: `valid_out` equals the `valid_in` sampled 11 rising edges earlier. A cycle with `valid_in` low produces no output cycle, whatever `data_in` carries.
- R3: Blocks presented on consecutive cycles leave on consecutive cycles, in order, and each one is correctly encrypted.
- R4: With the round keys expanded from cipher key 000102030405060708090a0b0c0d0e0f, plaintext 00112233445566778899aabbccddeeff yields ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: Byte k of a block (k = 0..15) sits in bits [127-8k -: 8]. It belongs to row k mod 4 and column k div 4 of the state, and row r rotates left by r byte positions. Round key j sits in bits [128j+127 : 128j] of `round_keys`.
- R6: While `valid_out` is low, `data_out` keeps the last ciphertext it delivered.
- R7: After the pipeline has drained, a new set of round keys applies to every later block. Cipher key 2b7e151628aed2a6abf7158809cf4f3c encrypts 3243f6a8885a308d313198a2e0370734 to 3925841d02dc09fbdc118597196a0b32.
- R8: With every round key set to zero, the all-zero and all-ones plaintexts encrypt to the values the cipher definition gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| valid_in | input | 1 | Qualifies `data_in` in this cycle |
| data_in | input | 128 | Plaintext block |
| round_keys | input | 1408 | Eleven precomputed round keys, key j in bits [128j+127:128j] |
| valid_out | output | 1 | Qualifies `data_out` in this cycle |
| data_out | output | 128 | Ciphertext block |

## Verification
The assertions take the round-key input to be quasi-static. It must not change in any cycle in which a block is entering the pipeline or is still inside it. The reset checks use the internally synchronized reset, not the raw pin. To stay within these limits, the stimulus always drains the pipeline with at least twelve idle cycles before it loads new keys. It then holds the new keys for one idle cycle before the next block enters. The stimulus also waits a few cycles after releasing reset so that the synchronizer has let go.

// File: rtl/aes128_pkg.sv
`timescale 1ns/1ps
package aes128_pkg;
  localparam int BLK_W    = 128;
  localparam int BYTE_W   = 8;
  localparam int N_BYTES  = BLK_W / BYTE_W;
  localparam int N_ROWS   = 4;
  localparam int N_COLS   = N_BYTES / N_ROWS;
  localparam int COL_W    = N_ROWS * BYTE_W;
  localparam int N_ROUNDS = 10;
  localparam logic [7:0] POLY_LOW  = 8'h1b;
  localparam logic [7:0] AFFINE_C  = 8'h63;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [BLK_W-1:0]  blk_t;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_x2(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? POLY_LOW : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc;
    byte_t p;
    acc = '0;
    p   = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_x2(p);
    end
    return acc;
  endfunction

  // a^254 equals the inverse (and maps 0 to 0)
  function automatic byte_t gf_inv(byte_t a);
    byte_t r;
    byte_t sq;
    r  = 8'h01;
    sq = a;
    for (int i = 1; i < BYTE_W; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic byte_t rotl8(byte_t v, int n);
    byte_t r;
    r = v;
    for (int i = 0; i < n; i++) r = {r[6:0], r[7]};
    return r;
  endfunction
endpackage

// File: rtl/aes128_sbox.sv
`timescale 1ns/1ps
module aes128_sbox
  import aes128_pkg::*;
(
  input  byte_t din,
  output byte_t dout
);
  byte_t inv;

  always_comb begin
    inv  = gf_inv(din);
    dout = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ AFFINE_C;
  end
endmodule

// File: rtl/aes128_mixcol.sv
`timescale 1ns/1ps
module aes128_mixcol
  import aes128_pkg::*;
(
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o
);
  byte_t a0, a1, a2, a3;
  byte_t d0, d1, d2, d3;

  always_comb begin
    a0 = col_i[COL_W-1           -: BYTE_W];
    a1 = col_i[COL_W-1-BYTE_W    -: BYTE_W];
    a2 = col_i[COL_W-1-2*BYTE_W  -: BYTE_W];
    a3 = col_i[COL_W-1-3*BYTE_W  -: BYTE_W];
    d0 = a0 ^ a1 ^ a2 ^ a3;
    // b_r = a_r ^ total ^ 2*(a_r ^ a_(r+1))
    col_o = {a0 ^ d0 ^ gf_x2(a0 ^ a1),
             a1 ^ d0 ^ gf_x2(a1 ^ a2),
             a2 ^ d0 ^ gf_x2(a2 ^ a3),
             a3 ^ d0 ^ gf_x2(a3 ^ a0)};
    d1 = '0;
    d2 = '0;
    d3 = '0;
  end
endmodule

// File: rtl/aes128_round.sv
`timescale 1ns/1ps
module aes128_round
  import aes128_pkg::*;
#(
  parameter bit FINAL = 1'b0
) (
  input  blk_t st_i,
  input  blk_t rk_i,
  output blk_t st_o
);
  byte_t sub_b [N_BYTES];
  byte_t rot_b [N_BYTES];
  byte_t mix_b [N_BYTES];

  for (genvar i = 0; i < N_BYTES; i++) begin : g_sub
    aes128_sbox u_sbox (
      .din  (st_i[BLK_W-1-BYTE_W*i -: BYTE_W]),
      .dout (sub_b[i])
    );
  end

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      assign rot_b[N_ROWS*c+r] = sub_b[N_ROWS*((c+r)%N_COLS)+r];
    end
  end

  if (FINAL) begin : g_nomix
    for (genvar i = 0; i < N_BYTES; i++) begin : g_pass
      assign mix_b[i] = rot_b[i];
    end
  end else begin : g_mix
    for (genvar c = 0; c < N_COLS; c++) begin : g_mc
      logic [COL_W-1:0] mc_out;
      aes128_mixcol u_mixcol (
        .col_i ({rot_b[N_ROWS*c], rot_b[N_ROWS*c+1], rot_b[N_ROWS*c+2], rot_b[N_ROWS*c+3]}),
        .col_o (mc_out)
      );
      for (genvar r = 0; r < N_ROWS; r++) begin : g_split
        assign mix_b[N_ROWS*c+r] = mc_out[COL_W-1-BYTE_W*r -: BYTE_W];
      end
    end
  end

  for (genvar i = 0; i < N_BYTES; i++) begin : g_ark
    assign st_o[BLK_W-1-BYTE_W*i -: BYTE_W] = mix_b[i] ^ rk_i[BLK_W-1-BYTE_W*i -: BYTE_W];
  end
endmodule

// File: rtl/aes128_stage.sv
`timescale 1ns/1ps
module aes128_stage #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_i,
  input  logic [W-1:0] d_i,
  output logic         v_o,
  output logic [W-1:0] d_o
);
  logic         v_d;
  logic         d_en;
  logic         v_q;
  logic [W-1:0] d_q;

  always_comb begin
    v_d  = v_i;
    d_en = v_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  // datapath flops: no reset, loaded only under a valid
  always_ff @(posedge clk) begin
    if (d_en) d_q <= d_i;
  end

  assign v_o = v_q;
  assign d_o = d_q;
endmodule

// File: rtl/aes128_pipe.sv
`timescale 1ns/1ps
module aes128_pipe
  import aes128_pkg::*;
#(
  parameter int N_ROUNDS = aes128_pkg::N_ROUNDS
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             valid_in,
  input  logic [aes128_pkg::BLK_W-1:0]     data_in,
  input  logic [(N_ROUNDS+1)*aes128_pkg::BLK_W-1:0] round_keys,
  output logic                             valid_out,
  output logic [aes128_pkg::BLK_W-1:0]     data_out
);
  localparam int N_RKEYS = N_ROUNDS + 1;
  localparam int KEYS_W  = N_RKEYS * BLK_W;

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic v_s   [N_RKEYS];
  blk_t d_s   [N_RKEYS];
  blk_t stg_in[N_RKEYS];

  assign stg_in[0] = data_in ^ round_keys[BLK_W-1:0];

  aes128_stage #(.W(BLK_W)) u_stage0 (
    .clk   (clk),
    .rst_n (rst_q),
    .v_i   (valid_in),
    .d_i   (stg_in[0]),
    .v_o   (v_s[0]),
    .d_o   (d_s[0])
  );

  for (genvar k = 1; k < N_RKEYS; k++) begin : g_rnd
    aes128_round #(.FINAL(k == N_ROUNDS)) u_round (
      .st_i (d_s[k-1]),
      .rk_i (round_keys[k*BLK_W +: BLK_W]),
      .st_o (stg_in[k])
    );
    aes128_stage #(.W(BLK_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_q),
      .v_i   (v_s[k-1]),
      .d_i   (stg_in[k]),
      .v_o   (v_s[k]),
      .d_o   (d_s[k])
    );
  end

  assign valid_out = v_s[N_ROUNDS];
  assign data_out  = d_s[N_ROUNDS];

  logic [KEYS_W-1:0] keys_unused_chk;
  assign keys_unused_chk = round_keys;
endmodule

// File: rtl/aes128_pipe_chk.sv
`timescale 1ns/1ps
module aes128_pipe_chk #(
  parameter int LAT = 11,
  parameter int KW  = 1408,
  parameter int BW  = 128
) (
  input logic          clk,
  input logic          rst_q,
  input logic          valid_in,
  input logic [KW-1:0] round_keys,
  input logic          valid_out,
  input logic [BW-1:0] data_out
);
  logic [LAT-1:0] vin_hist;
  logic           seen_out;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vin_hist <= '0;
      seen_out <= 1'b0;
    end else begin
      vin_hist <= {vin_hist[LAT-2:0], valid_in};
      if (valid_out) seen_out <= 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_q |-> !valid_out); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_q)
    valid_out == vin_hist[LAT-1]); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    (seen_out && !valid_out) |-> $stable(data_out)); // R6

  AST_KEYS_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    (valid_in || (|vin_hist)) |-> $stable(round_keys)); // R7
endmodule

bind aes128_pipe aes128_pipe_chk #(
  .LAT (N_ROUNDS + 1),
  .KW  ((N_ROUNDS + 1) * aes128_pkg::BLK_W),
  .BW  (aes128_pkg::BLK_W)
) u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .valid_in   (valid_in),
  .round_keys (round_keys),
  .valid_out  (valid_out),
  .data_out   (data_out)
);

// File: tb/sim_aes128_pipe.sv
`timescale 1ns/1ps
module sim_aes128_pipe;
  localparam int NR  = 10;
  localparam int BW  = 128;
  localparam int KW  = (NR + 1) * BW;
  localparam int LAT = NR + 1;

  logic          clk;
  logic          rst_n;
  logic          valid_in;
  logic [BW-1:0] data_in;
  logic [KW-1:0] keys;
  logic          valid_out;
  logic [BW-1:0] data_out;

  aes128_pipe u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_in   (valid_in),
    .data_in    (data_in),
    .round_keys (keys),
    .valid_out  (valid_out),
    .data_out   (data_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int            n_chk = 0;
  int            n_bad = 0;
  string         cur_req = "R1";
  logic          hv [LAT];
  logic [BW-1:0] hd [LAT];
  logic [BW-1:0] last_out;
  bit            seen_out;
  logic [7:0]    t_exp [256];
  int            t_log [256];

  // ---------------- reference model (log/antilog arithmetic) ----------------
  function automatic logic [7:0] m_x2(logic [7:0] a);
    return (a << 1) ^ ((a & 8'h80) != 0 ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return t_exp[(t_log[a] + t_log[b]) % 255];
  endfunction

  function automatic logic [7:0] m_sub(logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] s;
    inv = (x == 0) ? 8'h00 : t_exp[(255 - t_log[x]) % 255];
    s = 8'h63;
    for (int k = 0; k < 5; k++) s = s ^ ((inv << k) | (inv >> (8 - k)));
    return s;
  endfunction

  function automatic logic [KW-1:0] m_expand(logic [127:0] key);
    logic [31:0]   w [4*(NR+1)];
    logic [31:0]   t;
    logic [7:0]    rc;
    logic [KW-1:0] ks;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 4*(NR+1); i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {m_sub(t[23:16]), m_sub(t[15:8]), m_sub(t[7:0]), m_sub(t[31:24])} ^ {rc, 24'h0};
        rc = m_x2(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int j = 0; j <= NR; j++)
      ks[128*j +: 128] = {w[4*j], w[4*j+1], w[4*j+2], w[4*j+3]};
    return ks;
  endfunction

  function automatic logic [127:0] m_enc(logic [127:0] pt, logic [KW-1:0] ks);
    logic [7:0]   s [16];
    logic [7:0]   t [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ ks[127-8*i -: 8];
    for (int rnd = 1; rnd <= NR; rnd++) begin
      for (int i = 0; i < 16; i++) t[i] = m_sub(s[i]);
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[4*c+r] = t[4*((c+r)%4)+r];
      if (rnd < NR) begin
        for (int c = 0; c < 4; c++) begin
          for (int r = 0; r < 4; r++)
            t[r] = m_mul(8'h02, s[4*c+r]) ^ m_mul(8'h03, s[4*c+(r+1)%4])
                 ^ s[4*c+(r+2)%4] ^ s[4*c+(r+3)%4];
          for (int r = 0; r < 4; r++) s[4*c+r] = t[r];
        end
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ ks[128*rnd+127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  // ---------------- one clock of stimulus and comparison ----------------
  task automatic step(input logic v, input logic [BW-1:0] d, input logic [BW-1:0] e);
    @(negedge clk);
    n_chk++;
    if (valid_out !== hv[LAT-1]) begin
      n_bad++;
      $display("FAIL %s/R2 valid_out actual=%b expected=%b", cur_req, valid_out, hv[LAT-1]);
    end
    if (hv[LAT-1] === 1'b1) begin
      n_chk++;
      if (data_out !== hd[LAT-1]) begin
        n_bad++;
        $display("FAIL %s data_out actual=%h expected=%h", cur_req, data_out, hd[LAT-1]);
      end
      last_out = hd[LAT-1];
      seen_out = 1'b1;
    end else if (seen_out) begin
      n_chk++;
      if (data_out !== last_out) begin
        n_bad++;
        $display("FAIL R6 hold data_out actual=%h expected=%h", data_out, last_out);
      end
    end
    for (int k = LAT-1; k > 0; k--) begin
      hv[k] = hv[k-1];
      hd[k] = hd[k-1];
    end
    hv[0]    = v;
    hd[0]    = e;
    valid_in = v;
    data_in  = d;
  endtask

  task automatic push(input logic [BW-1:0] d);
    step(1'b1, d, m_enc(d, keys));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, {$urandom, $urandom, $urandom, $urandom}, '0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    cur_req = "R1";
    rst_n = 1'b0;
    valid_in = 1'b1;
    data_in = '1;
    for (int k = 0; k < LAT; k++) begin hv[k] = 1'b0; hd[k] = '0; end
    seen_out = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      n_chk++;
      if (valid_out !== 1'b0) begin
        n_bad++;
        $display("FAIL R1 valid_out in reset actual=%b expected=0", valid_out);
      end
    end
    valid_in = 1'b0;
    rst_n = 1'b1;
    idle(LAT + 4);
  endtask

  task automatic t_kat();
    cur_req = "R4";
    keys = m_expand(128'h000102030405060708090a0b0c0d0e0f);
    idle(1);
    step(1'b1, 128'h00112233445566778899aabbccddeeff, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    idle(LAT + 2);
  endtask

  task automatic t_stream();
    cur_req = "R3";
    for (int i = 0; i < 24; i++) push({$urandom, $urandom, $urandom, $urandom});
    idle(LAT + 1);
  endtask

  task automatic t_gaps();
    cur_req = "R2";
    for (int i = 0; i < 30; i++) begin
      if ((i % 3) == 1 || (i % 7) == 5) idle(1);
      else push({$urandom, $urandom, $urandom, i});
    end
    idle(LAT + 1);
  endtask

  task automatic t_order();
    cur_req = "R5";
    for (int k = 0; k < 16; k++) push(128'h80 << (8 * (15 - k)));
    idle(LAT + 1);
  endtask

  task automatic t_hold();
    cur_req = "R6";
    push(128'hdeadbeef_00000000_cafef00d_12345678);
    idle(LAT + 8);
  endtask

  task automatic t_zero_keys();
    cur_req = "R8";
    keys = '0;
    idle(1);
    push('0);
    push('1);
    push('0);
    idle(LAT + 1);
  endtask

  task automatic t_rekey();
    cur_req = "R7";
    keys = m_expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
    idle(1);
    step(1'b1, 128'h3243f6a8885a308d313198a2e0370734, 128'h3925841d02dc09fbdc118597196a0b32);
    push(128'h3243f6a8885a308d313198a2e0370735);
    idle(LAT + 1);
  endtask

  initial begin : main
    logic [7:0] x;
    x = 8'h01;
    for (int i = 0; i < 255; i++) begin
      t_exp[i] = x;
      t_log[x] = i;
      x = x ^ m_x2(x);
    end
    t_exp[255] = 8'h01;
    t_log[0]   = 0;
    keys = '0;
    valid_in = 1'b0;
    data_in = '0;
    t_reset();
    t_kat();
    t_stream();
    t_gaps();
    t_order();
    t_hold();
    t_zero_keys();
    t_rekey();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired during %s", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule